// File: doc/BRIEF.md
# Serial-Order Saturating Dot-Product Unit

This block computes a four-lane fixed-point dot product and adds it to a running 32-bit sum. Each cycle it can take two vectors of signed Q15 samples and a Q31 sum. Every lane pair is multiplied and scaled to Q31, and each product is clamped on its own. The clamped products are then folded into the sum one lane at a time, lowest lane first, and the sum is clamped after every single addition. The result therefore matches a plain scalar loop bit for bit, which speech and channel codecs need because saturating addition is not associative.

The datapath is cut into four register stages: two for the multiply and scaling, and two for the ordered additions with two chained adders each. A new operation can enter every cycle and results leave in issue order. A sticky flag records that some clamp has fired since software last cleared it. Passing the same vector on both operand inputs gives a sum of squares.

Top module: `sdot_serial_mac`

## Requirements
- R1: Lane i of each operand vector sits at bits [16*i+15 : 16*i] as a two's-complement Q15 value. The sum input and the result are 32-bit two's-complement Q31 values.
- R2: Each lane product is the exact product of its two lanes doubled into Q31. The one product that does not fit, -1.0 times -1.0 (0x8000 by 0x8000), is clamped to 0x7FFFFFFF and counts as a saturation.
- R3: The result is ((((sum + p0) + p1) + p2) + p3). Each partial sum is clamped to the range 0x80000000 to 0x7FFFFFFF before the next product is added.
- R4: in_ready stays high out of reset, so an operation is accepted in every cycle where in_valid is high. Its result appears on out_acc with out_valid high for exactly one cycle, four cycles after the accepting cycle, and results stay in acceptance order.
- R5: ovf_sticky goes high in the cycle a result appears if any product clamp or addition clamp fired for that operation. It then stays high until it is cleared.
- R6: ovf_clear held high in a cycle drives ovf_sticky low in the next cycle. The exception is a result appearing in that next cycle with a clamp of its own, in which case the flag is high (setting wins).
- R7: While rst_n is low, out_valid and ovf_sticky are low.
- R8: Identical vectors on both operand inputs give the clamped sum of squares added to the sum input.
- R9: A clamp on an early partial sum is kept: later products of the opposite sign start from the clamped value and do not recover the lost amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| in_ready | output | 1 | Unit can accept operands |
| in_vec_a | input | 64 | First operand vector, four Q15 lanes |
| in_vec_b | input | 64 | Second operand vector, four Q15 lanes |
| in_acc | input | 32 | Incoming Q31 sum |
| ovf_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result present this cycle |
| out_acc | output | 32 | Q31 result |
| ovf_sticky | output | 1 | Some clamp has fired since the last clear |

## Verification
Two events can land on the sticky flag in the same cycle: a clear request, and the arrival of a result that clamped. The bench issues a saturating operation, waits three cycles, and raises ovf_clear in the cycle just before that result is captured. It then checks that the flag still reads high. It also clears in a quiet cycle and checks that the flag drops. A reference model in the bench evaluates each lane and each addition in a scalar loop with wide integers. Its flag value is compared against the unit every cycle, so both orders of clear and set are judged against the same scalar reading of R5 and R6.

// File: rtl/sdot_pkg.sv
package sdot_pkg;
  parameter int LANES = 4;
  parameter int EW    = 16;
  parameter int AW    = 32;
  localparam int PW   = 2 * EW;

  typedef logic signed [EW-1:0] elem_t;
  typedef logic signed [PW-1:0] prod_t;
  typedef logic signed [AW-1:0] acc_t;

  typedef struct packed {
    logic sat;
    acc_t val;
  } sres_t;

  localparam acc_t  ACC_MAX  = {1'b0, {(AW-1){1'b1}}};
  localparam acc_t  ACC_MIN  = {1'b1, {(AW-1){1'b0}}};
  localparam prod_t PROD_MAX = {1'b0, {(PW-1){1'b1}}};
  localparam prod_t PROD_MIN = {1'b1, {(PW-1){1'b0}}};

  // exact signed product of two lanes
  function automatic prod_t elem_mul(elem_t a, elem_t b);
    return prod_t'(a) * prod_t'(b);
  endfunction

  // fractional scaling by two, clamped to the product range
  function automatic sres_t frac_double(prod_t p);
    sres_t r;
    prod_t d;
    d     = {p[PW-2:0], 1'b0};
    r.sat = (p[PW-1] != p[PW-2]);
    if (r.sat) d = p[PW-1] ? PROD_MIN : PROD_MAX;
    r.val = acc_t'(d);
    return r;
  endfunction

  // one saturating addition step
  function automatic sres_t sat_add(acc_t x, acc_t y);
    logic signed [AW:0] s;
    sres_t r;
    s     = {x[AW-1], x} + {y[AW-1], y};
    r.sat = (s[AW] != s[AW-1]);
    if (r.sat) r.val = s[AW] ? ACC_MIN : ACC_MAX;
    else       r.val = s[AW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/sdot_mul_pipe.sv
module sdot_mul_pipe import sdot_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_fire,
  input  logic [LANES*EW-1:0]  a_vec,
  input  logic [LANES*EW-1:0]  b_vec,
  input  acc_t                 acc_in,
  output logic                 v2,
  output acc_t                 acc2,
  output acc_t [LANES-1:0]     prod2,
  output logic                 sat2,
  output logic                 lane_sat_evt
);
  logic             v1;
  acc_t             acc1;
  prod_t            raw1 [LANES];
  sres_t            scaled [LANES];
  logic [LANES-1:0] lane_sat;

  // stage 1: raw lane products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v1 <= 1'b0;
    else        v1 <= in_fire;
  end

  always_ff @(posedge clk) begin
    if (in_fire) begin
      acc1 <= acc_in;
      for (int i = 0; i < LANES; i++)
        raw1[i] <= elem_mul(elem_t'(a_vec[i*EW +: EW]), elem_t'(b_vec[i*EW +: EW]));
    end
  end

  // scaling and per-lane clamp between stage 1 and stage 2
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      scaled[i]   = frac_double(raw1[i]);
      lane_sat[i] = scaled[i].sat;
    end
  end

  assign lane_sat_evt = v1 & (|lane_sat);

  // stage 2: clamped Q31 products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
  end

  always_ff @(posedge clk) begin
    if (v1) begin
      acc2 <= acc1;
      sat2 <= |lane_sat;
      for (int i = 0; i < LANES; i++) prod2[i] <= scaled[i].val;
    end
  end
endmodule

// File: rtl/sdot_add_chain.sv
module sdot_add_chain import sdot_pkg::*; #(
  parameter int TAKE = 2
) (
  input  acc_t            sum_in,
  input  acc_t [TAKE-1:0] terms,
  output acc_t            sum_out,
  output logic            any_sat
);
  acc_t            part [TAKE+1];
  sres_t           step [TAKE];
  logic [TAKE-1:0] hit;

  assign part[0] = sum_in;

  // terms[0] is added first; each step clamps before the next
  for (genvar j = 0; j < TAKE; j++) begin : g_step
    assign step[j]   = sat_add(part[j], terms[j]);
    assign part[j+1] = step[j].val;
    assign hit[j]    = step[j].sat;
  end

  assign sum_out = part[TAKE];
  assign any_sat = |hit;
endmodule

// File: rtl/sdot_serial_mac.sv
module sdot_serial_mac import sdot_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*EW-1:0] in_vec_a,
  input  logic [LANES*EW-1:0] in_vec_b,
  input  logic [AW-1:0]       in_acc,
  input  logic                ovf_clear,
  output logic                out_valid,
  output logic [AW-1:0]       out_acc,
  output logic                ovf_sticky
);
  localparam int HALF = LANES / 2;
  localparam int REST = LANES - HALF;

  logic             fire;
  logic             v2, sat2, mul_sat_evt;
  acc_t             acc2;
  acc_t [LANES-1:0] prod2;
  acc_t             sum_lo;
  logic             sat_lo;
  logic             v3, sat3;
  acc_t             sum3;
  acc_t [REST-1:0]  hi3;
  acc_t             sum_hi;
  logic             sat_hi;
  logic             fin_sat_evt;

  assign in_ready = 1'b1;
  assign fire     = in_valid & in_ready;

  sdot_mul_pipe u_mul (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_fire      (fire),
    .a_vec        (in_vec_a),
    .b_vec        (in_vec_b),
    .acc_in       (in_acc),
    .v2           (v2),
    .acc2         (acc2),
    .prod2        (prod2),
    .sat2         (sat2),
    .lane_sat_evt (mul_sat_evt)
  );

  // stage 3: sum plus the lower lanes, in lane order
  sdot_add_chain #(.TAKE(HALF)) u_add_lo (
    .sum_in  (acc2),
    .terms   (prod2[HALF-1:0]),
    .sum_out (sum_lo),
    .any_sat (sat_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v3 <= 1'b0;
    else        v3 <= v2;
  end

  always_ff @(posedge clk) begin
    if (v2) begin
      sum3 <= sum_lo;
      hi3  <= prod2[LANES-1:HALF];
      sat3 <= sat2 | sat_lo;
    end
  end

  // stage 4: the upper lanes, continuing the same order
  sdot_add_chain #(.TAKE(REST)) u_add_hi (
    .sum_in  (sum3),
    .terms   (hi3),
    .sum_out (sum_hi),
    .any_sat (sat_hi)
  );

  assign fin_sat_evt = v3 & (sat3 | sat_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v3;
  end

  always_ff @(posedge clk) begin
    if (v3) out_acc <= sum_hi;
  end

  // setting wins over clearing in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_sticky <= 1'b0;
    else        ovf_sticky <= (ovf_sticky & ~ovf_clear) | fin_sat_evt;
  end
endmodule

// File: rtl/sdot_serial_mac_chk.sv
module sdot_serial_mac_chk import sdot_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          ovf_clear,
  input logic          out_valid,
  input logic [AW-1:0] out_acc,
  input logic          ovf_sticky,
  input logic          mul_sat_evt,
  input logic          fin_sat_evt
);
  logic [2:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 3'd0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> (out_valid == $past(in_valid && in_ready, 4)));

  a_r4_known: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_acc));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clear) |=> ovf_sticky);

  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_sticky) |-> $past(fin_sat_evt));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fin_sat_evt |=> (ovf_sticky && out_valid));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clear && !fin_sat_evt) |=> !ovf_sticky);

  a_r2_product_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4 && $past(mul_sat_evt, 3)) |-> ovf_sticky);
endmodule

bind sdot_serial_mac sdot_serial_mac_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .ovf_clear   (ovf_clear),
  .out_valid   (out_valid),
  .out_acc     (out_acc),
  .ovf_sticky  (ovf_sticky),
  .mul_sat_evt (mul_sat_evt),
  .fin_sat_evt (fin_sat_evt)
);

// File: tb/sdot_serial_mac_test.sv
module sdot_serial_mac_test;
  import sdot_pkg::*;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic [LANES*EW-1:0] in_vec_a;
  logic [LANES*EW-1:0] in_vec_b;
  logic [AW-1:0]       in_acc;
  logic                ovf_clear;
  logic                out_valid;
  logic [AW-1:0]       out_acc;
  logic                ovf_sticky;

  always #5 clk = ~clk;

  sdot_serial_mac uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_vec_a   (in_vec_a),
    .in_vec_b   (in_vec_b),
    .in_acc     (in_acc),
    .ovf_clear  (ovf_clear),
    .out_valid  (out_valid),
    .out_acc    (out_acc),
    .ovf_sticky (ovf_sticky)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int iter   = 0;
  bit m_sticky = 1'b0;
  bit prev_clr = 1'b0;

  int            q_due [$];
  logic [AW-1:0] q_val [$];
  bit            q_sat [$];
  string         q_tag [$];

  // scalar loop with wide integers
  function automatic void model(input logic [LANES*EW-1:0] a, input logic [LANES*EW-1:0] b,
                                input logic [AW-1:0] acc, output logic [AW-1:0] res, output bit sat);
    longint s, p, hi, lo;
    hi  = (longint'(1) <<< (AW-1)) - 1;
    lo  = -(longint'(1) <<< (AW-1));
    s   = longint'($signed(acc));
    sat = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      p = longint'($signed(a[i*EW +: EW])) * longint'($signed(b[i*EW +: EW])) * 2;
      if (p > hi) begin p = hi; sat = 1'b1; end
      if (p < lo) begin p = lo; sat = 1'b1; end
      s = s + p;
      if (s > hi) begin s = hi; sat = 1'b1; end
      if (s < lo) begin s = lo; sat = 1'b1; end
    end
    res = s[AW-1:0];
  endfunction

  function automatic logic [LANES*EW-1:0] pk(logic [15:0] e0, logic [15:0] e1,
                                             logic [15:0] e2, logic [15:0] e3);
    return {e3, e2, e1, e0};
  endfunction

  function automatic logic [15:0] pick16();
    case ($urandom % 6)
      0:       return 16'h8000;
      1:       return 16'h7FFF;
      2:       return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [AW-1:0] pick_acc();
    case ($urandom % 5)
      0:       return 32'h7FFF_FFFF;
      1:       return 32'h8000_0000;
      default: return 32'($urandom);
    endcase
  endfunction

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_now();
    bit arr;
    arr = (q_due.size() != 0) && (q_due[0] == iter);
    m_sticky = (prev_clr ? 1'b0 : m_sticky) | (arr && q_sat[0]);
    note(out_valid === arr, arr ? q_tag[0] : "R4", "out_valid", 64'(out_valid), 64'(arr));
    if (arr) begin
      note(out_acc === q_val[0], q_tag[0], "out_acc", 64'(out_acc), 64'(q_val[0]));
      void'(q_due.pop_front());
      void'(q_val.pop_front());
      void'(q_sat.pop_front());
      void'(q_tag.pop_front());
    end
    note(ovf_sticky === m_sticky, "R5/R6", "ovf_sticky", 64'(ovf_sticky), 64'(m_sticky));
  endtask

  task automatic step(input bit v, input logic [LANES*EW-1:0] a, input logic [LANES*EW-1:0] b,
                      input logic [AW-1:0] acc, input bit clr, input string tag);
    logic [AW-1:0] r;
    bit            s;
    @(negedge clk);
    check_now();
    in_valid  = v;
    in_vec_a  = a;
    in_vec_b  = b;
    in_acc    = acc;
    ovf_clear = clr;
    if (v) begin
      note(in_ready === 1'b1, "R4", "in_ready", 64'(in_ready), 64'd1);
      model(a, b, acc, r, s);
      q_due.push_back(iter + 4);
      q_val.push_back(r);
      q_sat.push_back(s);
      q_tag.push_back(tag);
    end
    prev_clr = clr;
    iter++;
  endtask

  task automatic idle(input int n, input bit clr);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0, clr, "R4");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [LANES*EW-1:0] va;
    rst_n = 1'b0; in_valid = 1'b0; in_vec_a = '0; in_vec_b = '0; in_acc = '0; ovf_clear = 1'b0;
    // R7: reset state
    repeat (3) begin
      @(negedge clk);
      note(out_valid === 1'b0, "R7", "out_valid", 64'(out_valid), 64'd0);
      note(ovf_sticky === 1'b0, "R7", "ovf_sticky", 64'(ovf_sticky), 64'd0);
    end
    rst_n = 1'b1;

    // R1: lane placement, mixed signs, no clamp
    step(1, pk(16'h4000, 16'h2000, 16'hC000, 16'h0100),
            pk(16'h4000, 16'h4000, 16'h4000, 16'h7FFF), 32'h0000_1000, 0, "R1");
    // R8 and R3: squares that clamp on the last addition, back to back
    step(1, pk(16'h4000, 16'h4000, 16'h4000, 16'h4000),
            pk(16'h4000, 16'h4000, 16'h4000, 16'h4000), 32'h0, 0, "R8");
    // R2: -1.0 * -1.0 in lane 0
    step(1, pk(16'h8000, 16'h0, 16'h0, 16'h0), pk(16'h8000, 16'h0, 16'h0, 16'h0), 32'h0, 0, "R2");
    idle(5, 0);
    idle(1, 1);   // R6: quiet clear
    idle(2, 0);
    // R9: early clamp is not undone by a later negative product
    step(1, pk(16'h7FFF, 16'h8000, 16'h0, 16'h0), pk(16'h7FFF, 16'h4000, 16'h0, 16'h0),
            32'h7FFF_0000, 0, "R9");
    // R3: negative clamp
    step(1, pk(16'h8000, 16'h8000, 16'h8000, 16'h8000), pk(16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF),
            32'h8000_0010, 0, "R3");
    idle(5, 0);
    idle(1, 1);
    idle(2, 0);
    // R6: clear in the cycle the clamping result is captured
    step(1, pk(16'h8000, 16'h0, 16'h0, 16'h0), pk(16'h8000, 16'h0, 16'h0, 16'h0), 32'h0, 0, "R6");
    idle(2, 0);
    idle(1, 1);
    idle(3, 0);
    idle(1, 1);
    idle(3, 0);
    // R8: random sums of squares
    for (int k = 0; k < 30; k++) begin
      va = pk(pick16(), pick16(), pick16(), pick16());
      step(1, va, va, pick_acc(), 0, "R8");
    end
    // R3/R4: random bursts with random clears
    for (int k = 0; k < 400; k++) begin
      step(($urandom % 4) != 0, pk(pick16(), pick16(), pick16(), pick16()),
           pk(pick16(), pick16(), pick16(), pick16()), pick_acc(), ($urandom % 16) == 0, "R3");
    end
    idle(6, 0);
    summary();
    $finish;
  end
endmodule